// File: doc/BRIEF.md
# Eight-channel pin interrupt controller

This block turns eight selected pin inputs into eight interrupt requests for a parent interrupt controller. Each channel is either edge-sensitive or level-sensitive. An edge-sensitive channel can fire on rising edges, falling edges or both. A level-sensitive channel fires while its input sits at a chosen polarity. The pins reach the block asynchronously and pass through a synchronizer first. Channel k drives parent interrupt line 32 + k, and the block exposes nothing of that numbering beyond bit k of `irq_o`.

Software controls the block through a 32-bit register bus. Writes take effect on the clock edge where `wr_en_i` is high. A read is requested with `rd_en_i`, and `rdata_o` holds the result in the following cycle. Enables are never written directly. Dedicated set and clear registers change them, so that two agents can each change their own channels without a read-modify-write. Edge events stay latched until software clears them, either per edge direction or through the status register.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is zero.
- R2: A 1 written to a bit of the rising set register (0x08) or clear register (0x0C) sets or clears that channel's rising/level enable, readable at 0x04. The falling set register (0x14) and clear register (0x18) do the same for the falling/polarity bit, readable at 0x10. Bits written 0 leave their channel unchanged.
- R3: The mode register at 0x00 is written directly. Bit k = 0 puts channel k in edge mode, and bit k = 1 puts it in level mode.
- R4: Every rising edge of a synchronized input sets that channel's bit in 0x1C, and every falling edge sets its bit in 0x20. This happens regardless of mode and enables, within three clock cycles of the pin change. A latched bit stays set until it is cleared.
- R5: In edge mode, `irq_o[k]` is 1 exactly when (the rising latch and rising enable are both set) or (the falling latch and falling enable are both set).
- R6: A 1 written to a bit of 0x1C or 0x20 clears that latched edge. If a new edge of the same direction arrives in the same cycle, the latch stays set.
- R7: In edge mode, a 1 written to bit k of the status register 0x24 clears both of channel k's edge latches.
- R8: In level mode, `irq_o[k]` is 1 exactly when the rising/level enable is set and the synchronized input equals the polarity bit (1 = active-high, 0 = active-low).
- R9: In level mode, a 1 written to bit k of 0x24 toggles channel k's polarity bit and leaves its edge latches unchanged.
- R10: A read returns data in the cycle after `rd_en_i`. Register 0x24 reads back the current `irq_o`. The write-only set and clear registers, and unmapped addresses, read zero. Bits above bit 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| pin_i | input | 8 | Asynchronous channel inputs |
| irq_o | output | 8 | Per-channel interrupt requests to the parent controller |

## Verification
The hardest case to reach is a software clear of an edge latch that lands in the same cycle as a fresh edge of the same direction. The outcome depends on hitting one exact clock edge behind the two-stage synchronizer. The stimulus changes the pin half a cycle before a clock edge and waits exactly two clock periods. It then issues the clear write, so that the write lands on the edge where the new event is latched, and reads back the latch afterwards. Random sequences of mode, enable, pin and clear operations cover the remaining interleavings, and the output is checked after every step.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  // Word indices (byte offset / 4) of the software-visible registers
  localparam int unsigned WI_MODE = 0;
  localparam int unsigned WI_RENA = 1;
  localparam int unsigned WI_RSET = 2;
  localparam int unsigned WI_RCLR = 3;
  localparam int unsigned WI_FENA = 4;
  localparam int unsigned WI_FSET = 5;
  localparam int unsigned WI_FCLR = 6;
  localparam int unsigned WI_RDET = 7;
  localparam int unsigned WI_FDET = 8;
  localparam int unsigned WI_STAT = 9;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } chan_mode_e;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) stage_q[0] <= '0;
    else       stage_q[0] <= d_i;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[gi] <= '0;
      else       stage_q[gi] <= stage_q[gi-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinirq_chan.sv
module pinirq_chan
  import pinirq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic lvl_i,     // synchronized pin
  input  logic mode_i,    // chan_mode_e encoding
  input  logic rena_i,
  input  logic fena_i,
  input  logic rclr_i,
  input  logic fclr_i,
  input  logic sclr_i,    // status clear, edge mode only
  output logic rdet_o,
  output logic fdet_o,
  output logic stat_o
);
  logic prev_q, rdet_q, fdet_q;
  logic rise_ev, fall_ev;

  assign rise_ev = lvl_i & ~prev_q;
  assign fall_ev = ~lvl_i & prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      rdet_q <= 1'b0;
      fdet_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      // a fresh event outranks a clear issued in the same cycle
      if (rise_ev)               rdet_q <= 1'b1;
      else if (rclr_i || sclr_i) rdet_q <= 1'b0;
      if (fall_ev)               fdet_q <= 1'b1;
      else if (fclr_i || sclr_i) fdet_q <= 1'b0;
    end
  end

  always_comb begin
    if (chan_mode_e'(mode_i) == MODE_LEVEL)
      stat_o = rena_i & (lvl_i == fena_i);
    else
      stat_o = (rdet_q & rena_i) | (fdet_q & fena_i);
  end

  assign rdet_o = rdet_q;
  assign fdet_o = fdet_q;
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] mode_o,
  output logic [NUM_CH-1:0] rena_o,
  output logic [NUM_CH-1:0] fena_o,
  output logic [NUM_CH-1:0] rclr_o,
  output logic [NUM_CH-1:0] fclr_o,
  output logic [NUM_CH-1:0] sclr_o,
  input  logic [NUM_CH-1:0] rdet_i,
  input  logic [NUM_CH-1:0] fdet_i,
  input  logic [NUM_CH-1:0] stat_i
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [NUM_CH-1:0] mode_q, rena_q, fena_q;
  logic [NUM_CH-1:0] wmask, rd_word;
  logic [DATA_W-1:0] rdata_q;
  int unsigned       widx;

  assign wmask = wdata_i[NUM_CH-1:0];
  assign widx  = 32'(addr_i[ADDR_W-1:ADDR_W-IDX_W]);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q <= '0;
      rena_q <= '0;
      fena_q <= '0;
    end else if (wr_en_i) begin
      case (widx)
        WI_MODE: mode_q <= wmask;
        WI_RSET: rena_q <= rena_q | wmask;
        WI_RCLR: rena_q <= rena_q & ~wmask;
        WI_FSET: fena_q <= fena_q | wmask;
        WI_FCLR: fena_q <= fena_q & ~wmask;
        WI_STAT: fena_q <= fena_q ^ (wmask & mode_q);
        default: ;
      endcase
    end
  end

  assign rclr_o = (wr_en_i && widx == WI_RDET) ? wmask : '0;
  assign fclr_o = (wr_en_i && widx == WI_FDET) ? wmask : '0;
  assign sclr_o = (wr_en_i && widx == WI_STAT) ? (wmask & ~mode_q) : '0;

  always_comb begin
    case (widx)
      WI_MODE: rd_word = mode_q;
      WI_RENA: rd_word = rena_q;
      WI_FENA: rd_word = fena_q;
      WI_RDET: rd_word = rdet_i;
      WI_FDET: rd_word = fdet_i;
      WI_STAT: rd_word = stat_i;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= DATA_W'(rd_word);
    else              rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
  assign mode_o  = mode_q;
  assign rena_o  = rena_q;
  assign fena_o  = fena_q;
endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] pin_sync;
  logic [NUM_CH-1:0] mode_w, rena_w, fena_w;
  logic [NUM_CH-1:0] rclr_w, fclr_w, sclr_w;
  logic [NUM_CH-1:0] rdet_w, fdet_w, stat_w;

  pinirq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pin_i), .q_o(pin_sync)
  );

  pinirq_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .mode_o(mode_w), .rena_o(rena_w), .fena_o(fena_w),
    .rclr_o(rclr_w), .fclr_o(fclr_w), .sclr_o(sclr_w),
    .rdet_i(rdet_w), .fdet_i(fdet_w), .stat_i(stat_w)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_chan
    pinirq_chan chan_i (
      .clk_i(clk_i), .rst_i(rst_i),
      .lvl_i(pin_sync[gc]), .mode_i(mode_w[gc]),
      .rena_i(rena_w[gc]), .fena_i(fena_w[gc]),
      .rclr_i(rclr_w[gc]), .fclr_i(fclr_w[gc]), .sclr_i(sclr_w[gc]),
      .rdet_o(rdet_w[gc]), .fdet_o(fdet_w[gc]), .stat_o(stat_w[gc])
    );
  end

  assign irq_o = stat_w;
endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] mode_w,
  input logic [NUM_CH-1:0] rena_w,
  input logic [NUM_CH-1:0] fena_w,
  input logic [NUM_CH-1:0] rdet_w
);
  logic [ADDR_W-3:0] widx;
  logic [NUM_CH-1:0] wm;
  assign widx = addr_i[ADDR_W-1:2];
  assign wm   = wdata_i[NUM_CH-1:0];

  AST_EDGE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_o & ~mode_w & ~(rena_w | fena_w)) == '0); // R5

  AST_SET_ONLY_RAISES: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && widx == 2) |=> rena_w == ($past(rena_w) | $past(wm))); // R2

  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && widx == 3) |=> rena_w == ($past(rena_w) & ~$past(wm))); // R2

  AST_STATUS_TOGGLES_POL: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && widx == 9) |=> (fena_w ^ $past(fena_w)) == ($past(wm) & $past(mode_w))); // R9

  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_en_i && (widx == 7 || widx == 9)) |=> (($past(rdet_w) & ~rdet_w) == '0)); // R4
endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .mode_w(mode_w), .rena_w(rena_w),
  .fena_w(fena_w), .rdet_w(rdet_w)
);

// File: tb/pinirq_ctrl_tb_top.sv
module pinirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  pins, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_mode, m_rena, m_fena, m_rd, m_fd, m_pins;

  always #4 clk = ~clk;

  pinirq_ctrl dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pin_i(pins), .irq_o(irq)
  );

  function automatic logic [7:0] exp_irq();
    return (m_mode & m_rena & ~(m_pins ^ m_fena)) |
           (~m_mode & ((m_rd & m_rena) | (m_fd & m_fena)));
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_pins(input logic [7:0] v);
    m_rd |= v & ~m_pins;
    m_fd |= ~v & m_pins;
    m_pins = v;
    pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic apply_wr(input logic [5:0] a, input logic [7:0] w);
    case (a)
      6'h00: m_mode = w;
      6'h08: m_rena |= w;
      6'h0C: m_rena &= ~w;
      6'h14: m_fena |= w;
      6'h18: m_fena &= ~w;
      6'h1C: m_rd &= ~w;
      6'h20: m_fd &= ~w;
      6'h24: begin
        m_rd &= ~(w & ~m_mode);
        m_fd &= ~(w & ~m_mode);
        m_fena ^= w & m_mode;
      end
      default: ;
    endcase
    reg_wr(a, {24'h0, w});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [5:0] addrs [6] = '{6'h00, 6'h04, 6'h10, 6'h1C, 6'h20, 6'h24};
    void'($urandom(32'd2024));
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; pins = 0;
    m_mode = 0; m_rena = 0; m_fena = 0; m_rd = 0; m_fd = 0; m_pins = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {24'h0, irq}, 32'h0);
    for (int i = 0; i < 10; i++) begin
      reg_rd(6'(i * 4), d);
      check("R1 reg", d, 32'h0);
    end

    // R2 set/clear only touch bits written 1
    apply_wr(6'h08, 8'h05); apply_wr(6'h08, 8'h02); apply_wr(6'h0C, 8'h04);
    reg_rd(6'h04, d); check("R2 rena", d, 32'h03);
    apply_wr(6'h14, 8'hF0); apply_wr(6'h18, 8'h30);
    reg_rd(6'h10, d); check("R2 fena", d, 32'hC0);
    apply_wr(6'h0C, 8'hFF); apply_wr(6'h18, 8'hFF);

    // R3 mode register direct write
    apply_wr(6'h00, 8'h5A);
    reg_rd(6'h00, d); check("R3 mode", d, 32'h5A);
    apply_wr(6'h00, 8'h00);

    // R4/R5 rising latch and edge-mode irq
    apply_wr(6'h08, 8'h01);
    set_pins(8'h01);
    reg_rd(6'h1C, d); check("R4 rise latch", d, 32'h01);
    reg_rd(6'h20, d); check("R4 no fall latch", d, 32'h00);
    check("R5 irq rising", {24'h0, irq}, 32'h01);

    // R6 clear of rising latch
    apply_wr(6'h1C, 8'h01);
    check("R6 irq after clear", {24'h0, irq}, 32'h00);

    // R4/R5 falling latch, falling enable only
    apply_wr(6'h14, 8'h01);
    set_pins(8'h00);
    reg_rd(6'h20, d); check("R4 fall latch", d, 32'h01);
    check("R5 irq falling", {24'h0, irq}, 32'h01);

    // R7 status write clears both latches in edge mode
    apply_wr(6'h24, 8'h01);
    reg_rd(6'h20, d); check("R7 fall cleared", d, 32'h00);
    check("R7 irq cleared", {24'h0, irq}, 32'h00);

    // R6 collision: clear lands on the same edge as a new rising event
    pins = 8'h01; m_rd |= 8'h01; m_pins = 8'h01;
    repeat (2) @(negedge clk);
    reg_wr(6'h1C, 32'h01);
    repeat (2) @(negedge clk);
    reg_rd(6'h1C, d); check("R6 edge wins over clear", d, 32'h01);
    apply_wr(6'h1C, 8'h01);
    apply_wr(6'h0C, 8'h01); apply_wr(6'h18, 8'h01);
    set_pins(8'h00); apply_wr(6'h20, 8'hFF);

    // R8 level mode on channel 3, active low then active high
    apply_wr(6'h00, 8'h08); apply_wr(6'h08, 8'h08);
    repeat (2) @(negedge clk);
    check("R8 active-low match", {24'h0, irq}, 32'h08);
    apply_wr(6'h14, 8'h08);
    check("R8 active-high no match", {24'h0, irq}, 32'h00);
    set_pins(8'h08);
    check("R8 active-high match", {24'h0, irq}, 32'h08);

    // R9 status write toggles polarity, latches untouched
    reg_rd(6'h1C, d);
    apply_wr(6'h24, 8'h08);
    reg_rd(6'h10, d); check("R9 polarity toggled", d, 32'h00);
    check("R9 irq follows", {24'h0, irq}, 32'h00);
    reg_rd(6'h1C, d); check("R9 latch kept", d, {24'h0, m_rd});

    // R10 write-only and unmapped reads
    reg_rd(6'h08, d); check("R10 set reads zero", d, 32'h0);
    reg_rd(6'h3C, d); check("R10 unmapped zero", d, 32'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      logic [7:0] v;
      op = $urandom % 9;
      v  = 8'($urandom);
      case (op)
        0: apply_wr(6'h00, v);
        1: apply_wr(6'h08, v);
        2: apply_wr(6'h0C, v);
        3: apply_wr(6'h14, v);
        4: apply_wr(6'h18, v);
        5: apply_wr(6'h1C, v);
        6: apply_wr(6'h20, v);
        7: apply_wr(6'h24, v);
        default: set_pins(v);
      endcase
      check("R5/R8 random irq", {24'h0, irq}, {24'h0, exp_irq()});
      if (it % 8 == 0) begin
        for (int k = 0; k < 6; k++) begin
          logic [7:0] e;
          case (k)
            0: e = m_mode; 1: e = m_rena; 2: e = m_fena;
            3: e = m_rd;   4: e = m_fd;   default: e = exp_irq();
          endcase
          reg_rd(addrs[k], d);
          check("R10 random readback", d, {24'h0, e});
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule